// File: doc/BRIEF.md
# GPIO Input Qualification Filter

This block cleans up the 32 raw inputs of a general-purpose input port before the rest of the chip sees them. Every pin first passes through a two-stage synchronizer. Depending on a per-pin mode, the synchronized level is then either forwarded at once or sampled at a programmable interval. In the filtered case, the pin's output only moves to a new level once a run of 3 or 6 consecutive samples all show that level. Shorter glitches are absorbed.

The pins are split into four banks of eight. Each bank takes its sampling interval from its own byte of a 32-bit period register. The interval encoding is not linear. A code of zero samples on every clock. Any other code n samples once every 2·n clocks, so the largest code stretches the interval to 510 clocks. The period register can be written only while a write-permit input is high, and it can be read back at all times.

Top module: `gpio_qual_filter`

## Requirements
- R1: After reset the period register reads 0x00000000. `per_rd` always shows the register's current contents.
- R2: When `per_we` and `per_permit` are both high at a clock edge, the register takes `per_wdata` and shows it on `per_rd` from the next cycle.
- R3: A write presented while `per_permit` is low leaves the register and every output unchanged.
- R4: A bank period code of 0x00 takes one sample of that bank's pins on every clock.
- R5: A nonzero bank code n spaces samples exactly 2·n clocks apart, so code 0xFF gives 510 clocks.
- R6: Byte k of the register (bits 8k+7:8k) sets the period of pins 8k to 8k+7 and no other pins.
- R7: Pin mode 2'b01 (bits 2p+1:2p of `mode_sel`) is the 3-sample window. The output takes a level only when the newest 3 samples all equal it, and otherwise holds.
- R8: Pin mode 2'b10 is the 6-sample window. The output takes a level only when the newest 6 samples all equal it, and otherwise holds.
- R9: Pin modes 2'b00 and 2'b11 bypass the window. A change at `pin_in` appears on `qual_out` 3 clock edges later.
- R10: A period code written while a bank is mid-interval does not shorten or lengthen that interval. It governs the interval that begins at the next sample.
- R11: After reset all qualified outputs are 0 and every sample history holds zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| per_we | input | 1 | Period register write strobe |
| per_permit | input | 1 | Write permit; writes are dropped while low |
| per_wdata | input | 32 | Period register write data |
| per_rd | output | 32 | Period register read data |
| mode_sel | input | 64 | Two mode bits per pin |
| pin_in | input | 32 | Raw asynchronous pin levels |
| qual_out | output | 32 | Qualified pin levels |

## Verification
The hardest case to reach from the ports is a period rewrite that lands partway through a long interval. It has to be timed so that the interval already running can be told apart from the next one. The stimulus sets a bank to a long code and lets several samples pass. It then writes a much shorter code at an arbitrary cycle, while a slow input edge is being qualified on 3- and 6-sample pins. A cycle-exact reference model then shows whether the old interval ran to its end. Glitch trains at every clock, and level holds that last just under and just over a full window, exercise the hold-versus-update decision at its boundary.

// File: rtl/gqf_pkg.sv
package gqf_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_WIN3  = 2'b01,
    MODE_WIN6  = 2'b10,
    MODE_PASS2 = 2'b11
  } pin_mode_t;

  localparam int SHORT_WIN = 3;
  localparam int LONG_WIN  = 6;
endpackage

// File: rtl/gqf_period_reg.sv
module gqf_period_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         permit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we && permit) q <= wdata;
  end

  // R3: a write without permit is dropped
  assert_locked_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (we && !permit) |=> $stable(q));
  // R2: a permitted write is visible the next cycle
  assert_permitted_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (we && permit) |=> (q == $past(wdata)));
endmodule

// File: rtl/gqf_prescaler.sv
module gqf_prescaler #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              strobe
);
  localparam int CNT_W = CODE_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  always_comb begin
    if (code == '0) reload = '0;
    else reload = {code, 1'b0} - CNT_W'(1);
  end

  assign strobe = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (strobe) cnt <= reload;
    else cnt <= cnt - CNT_W'(1);
  end

  // R4: code zero samples again on the very next clock
  assert_code0_back_to_back_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe && code == '0) |=> strobe);
  // R5: nonzero code leaves a gap of at least one idle clock
  assert_nonzero_code_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe && code != '0) |=> !strobe);
endmodule

// File: rtl/gqf_pin_filter.sv
module gqf_pin_filter
  import gqf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       raw,
  input  logic       sample,
  input  logic [1:0] mode,
  output logic       qout
);
  localparam int HW = LONG_WIN;

  logic          sync1, sync2;
  logic [HW-1:0] hist;
  logic          short_hi, short_lo, long_hi, long_lo;
  pin_mode_t     m;

  assign m = pin_mode_t'(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else if (sample) hist <= {hist[HW-2:0], sync2};
  end

  assign short_hi = &hist[SHORT_WIN-1:0];
  assign short_lo = ~|hist[SHORT_WIN-1:0];
  assign long_hi  = &hist;
  assign long_lo  = ~|hist;

  always_ff @(posedge clk) begin
    if (rst) qout <= 1'b0;
    else begin
      case (m)
        MODE_WIN3: begin
          if (short_hi) qout <= 1'b1;
          else if (short_lo) qout <= 1'b0;
        end
        MODE_WIN6: begin
          if (long_hi) qout <= 1'b1;
          else if (long_lo) qout <= 1'b0;
        end
        default: qout <= sync2;
      endcase
    end
  end

  // R7: a rise under the short window follows three high samples
  assert_win3_rise_needs_run_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(qout) && $past(mode) == 2'b01) |-> ($past(hist[2:0]) == 3'b111));
  // R8: a fall under the long window follows six low samples
  assert_win6_fall_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(qout) && $past(mode) == 2'b10) |-> ($past(hist) == 6'b000000));
endmodule

// File: rtl/gpio_qual_filter.sv
module gpio_qual_filter #(
  parameter int NPINS  = 32,
  parameter int BANK   = 8,
  parameter int CODE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               per_we,
  input  logic               per_permit,
  input  logic [NPINS-1:0]   per_wdata,
  output logic [NPINS-1:0]   per_rd,
  input  logic [2*NPINS-1:0] mode_sel,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   qual_out
);
  localparam int NBANKS = NPINS / BANK;
  localparam int REG_W  = NBANKS * CODE_W;

  logic [REG_W-1:0]  per_q;
  logic [NBANKS-1:0] bank_stb;

  gqf_period_reg #(.W(REG_W)) u_reg (
    .clk(clk), .rst(rst), .we(per_we), .permit(per_permit),
    .wdata(per_wdata[REG_W-1:0]), .q(per_q)
  );

  assign per_rd = NPINS'(per_q);

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    gqf_prescaler #(.CODE_W(CODE_W)) u_pre (
      .clk(clk), .rst(rst),
      .code(per_q[b*CODE_W +: CODE_W]),
      .strobe(bank_stb[b])
    );
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gqf_pin_filter u_pin (
      .clk(clk), .rst(rst), .raw(pin_in[p]),
      .sample(bank_stb[p / BANK]),
      .mode(mode_sel[2*p +: 2]),
      .qout(qual_out[p])
    );
  end

  // R11: outputs leave reset at zero
  assert_outputs_clear_after_reset_R11: assert property (@(posedge clk)
    $fell(rst) |-> (qual_out == '0));
endmodule

// File: tb/gpio_qual_filter_tb_top.sv
module gpio_qual_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic          clk = 0;
  logic          rst = 1;
  logic          per_we = 0, per_permit = 0;
  logic [31:0]   per_wdata = 0;
  logic [31:0]   per_rd;
  logic [63:0]   mode_sel = 0;
  logic [31:0]   pin_in = 0;
  logic [31:0]   qual_out;

  int    n_vec = 0, n_bad = 0, cycles = 0;
  string cur_req = "R11";
  logic  cmp_on = 0;

  // reference model state
  logic [31:0] m_ctrl, m_s1, m_s2, m_out, n_out;
  int          m_cnt[4];
  int          hq[32][$];
  logic [3:0]  stb;
  logic [31:0] lf = 32'hACE1_2BD7;

  gpio_qual_filter dut_i (
    .clk(clk), .rst(rst), .per_we(per_we), .per_permit(per_permit),
    .per_wdata(per_wdata), .per_rd(per_rd), .mode_sel(mode_sel),
    .pin_in(pin_in), .qual_out(qual_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit run_is(int p, int k, logic v);
    for (int i = 0; i < k; i++) if (hq[p][i] != v) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ctrl = 0; m_s1 = 0; m_s2 = 0; m_out = 0;
      for (int g = 0; g < 4; g++) m_cnt[g] = 0;
      for (int p = 0; p < NP; p++) begin
        hq[p].delete();
        for (int i = 0; i < 6; i++) hq[p].push_back(1'b0);
      end
    end else begin
      for (int g = 0; g < 4; g++) stb[g] = (m_cnt[g] == 0);
      for (int p = 0; p < NP; p++) begin
        int md;
        md = int'(mode_sel[2*p +: 2]);
        n_out[p] = m_out[p];
        if (md == 1) begin
          if (run_is(p, 3, 1'b1)) n_out[p] = 1'b1;
          else if (run_is(p, 3, 1'b0)) n_out[p] = 1'b0;
        end else if (md == 2) begin
          if (run_is(p, 6, 1'b1)) n_out[p] = 1'b1;
          else if (run_is(p, 6, 1'b0)) n_out[p] = 1'b0;
        end else n_out[p] = m_s2[p];
      end
      for (int p = 0; p < NP; p++)
        if (stb[p/8]) begin
          hq[p].push_front(m_s2[p]);
          void'(hq[p].pop_back());
        end
      for (int g = 0; g < 4; g++) begin
        int code;
        code = int'(m_ctrl[8*g +: 8]);
        if (stb[g]) m_cnt[g] = (code == 0) ? 0 : 2*code - 1;
        else m_cnt[g] = m_cnt[g] - 1;
      end
      m_out = n_out;
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (per_we && per_permit) m_ctrl = per_wdata;
    end
    if (cycles > 190000) begin
      n_bad++;
      $display("FAIL watchdog expired (%s): actual cycles=%0d expected <=190000", cur_req, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_vec++;
      if (qual_out !== m_out || per_rd !== m_ctrl) begin
        n_bad++;
        $display("FAIL %s: actual out=%h rd=%h expected out=%h rd=%h",
                 cur_req, qual_out, per_rd, m_out, m_ctrl);
      end
    end
  end

  task automatic check_direct(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d, logic pm);
    @(negedge clk);
    per_we = 1; per_permit = pm; per_wdata = d;
    @(negedge clk);
    per_we = 0; per_permit = 0;
  endtask

  task automatic drive(int n, int hold, string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i % hold == 0) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        pin_in = lf;
      end
    end
  endtask

  initial begin
    // modes by pin: p%4 -> 00 pass, 01 win3, 10 win6, 11 pass
    for (int p = 0; p < NP; p++) mode_sel[2*p +: 2] = 2'(p % 4);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_direct("R11", qual_out, 32'h0);
    check_direct("R1", per_rd, 32'h0);
    cmp_on = 1;
    // R3: write without permit
    cur_req = "R3";
    wr(32'h1234_5678, 1'b0);
    check_direct("R3", per_rd, 32'h0);
    // R4: code 0 everywhere, glitchy input
    drive(300, 1, "R4");
    drive(300, 4, "R7");
    // R2/R6: distinct bank codes
    cur_req = "R2";
    wr(32'hFF02_0100, 1'b1);
    check_direct("R2", per_rd, 32'hFF02_0100);
    drive(800, 3, "R6");
    drive(1500, 9, "R8");
    drive(12000, 700, "R5");
    // R10: rewrite mid interval while slow edges are being qualified
    cur_req = "R10";
    wr(32'h0103_0205, 1'b1);
    drive(600, 25, "R10");
    wr(32'h8000_0007, 1'b1);
    drive(5000, 400, "R10");
    wr(32'h0000_0000, 1'b1);
    // R9: pass-through modes with code 0 and glitches
    drive(400, 1, "R9");
    // R3 again while running
    wr(32'hDEAD_BEEF, 1'b0);
    check_direct("R3", per_rd, 32'h0);
    drive(200, 2, "R3");
    cmp_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule